// File: doc/BRIEF.md
# Low-Power Stop Mode Controller

This block decides which low-power stop state the chip enters when the CPU reports a stop instruction, and it sequences the entry into that state and the exit from it. The stop request is one cycle wide. In that same cycle the block samples five configuration bits: stop permission, debug enable, the two low-voltage-detect enables and the power-down select. From these it picks one of three stop states. It can also refuse the request and raise an illegal-opcode reset instead.

While the block is stopped, it gates the bus and CPU clocks. It also drives the regulator-hold and power-down controls that the chosen state needs. It watches the external reset pin and a vector of wake interrupt requests, each with its own enable. A wake releases the clock gate and reports whether the reset pin or an interrupt caused it. One cycle later the block sends a completion pulse to the CPU.

The held state is visible on a 2-bit mode output with these codes: 00 run, 01 shallow stop, 10 shallow stop with regulator held, 11 deep power-down stop.

Top module: `stop_ctl`

## Requirements
- R1: A stop request while in run with `stop_en` = 0 raises `illegal_rst` for exactly one cycle, on the cycle after the request. No stop state is entered, `clk_gate` stays 0 and `mode_o` stays 00. This case takes precedence over the abort in R11.
- R2: With `stop_en` = 1 and `dbg_en` = 1, a request enters shallow stop (`mode_o` = 01) whatever the other selection bits are. `int_clk_on` is 1 while in that state, and `vreg_active` and `pdown` stay 0.
- R3: With `stop_en` = 1, `dbg_en` = 0, `lvd_en` = 1 and `lvd_stop_en` = 1, a request enters shallow stop with the regulator held (`mode_o` = 10, `vreg_active` = 1). A power-down request (`pdown_sel` = 1) is demoted to this state.
- R4: With `stop_en` = 1, `dbg_en` = 0 and either detect bit at 0, `pdown_sel` = 0 gives `mode_o` = 01 and `pdown_sel` = 1 gives `mode_o` = 11 with `pdown` = 1.
- R5: In every stop state `clk_gate` is 1. It rises on the cycle after the accepted request and stays high until the wake edge.
- R6: The selection bits are sampled only at the request. Changes to them while stopped, and further stop requests, leave `mode_o` and the controls unchanged.
- R7: Only a wake source whose bit is set in both `wake_req` and `wake_en` ends a stop. A request whose enable bit is 0 is ignored.
- R8: `rst_pin` = 1 while stopped ends the stop with `wake` = 1 and `wake_cause` = 1 on the next cycle. This holds even if an interrupt is also present.
- R9: An enabled interrupt with `rst_pin` = 0 ends the stop with `wake` = 1 and `wake_cause` = 0 on the next cycle.
- R10: On the cycle where `wake` is 1, `clk_gate` is already 0 and `mode_o` is 00. `done` is 1 on the following cycle only.
- R11: If an enabled wake request is present in the same cycle as an accepted stop request, no stop state is entered. `done` pulses on the next cycle, and neither `wake` nor `clk_gate` rises.
- R12: After synchronous reset, `mode_o` = 00 and every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_req | input | 1 | One-cycle stop instruction strobe from the CPU |
| stop_en | input | 1 | Stop permitted |
| dbg_en | input | 1 | Debug logic enabled |
| lvd_en | input | 1 | Low-voltage detect enabled |
| lvd_stop_en | input | 1 | Low-voltage detect kept alive in stop |
| pdown_sel | input | 1 | Request the deep power-down stop |
| rst_pin | input | 1 | External reset pin, active high |
| wake_req | input | NSRC | Wake interrupt requests |
| wake_en | input | NSRC | Per-source wake enable |
| clk_gate | output | 1 | 1 = bus and CPU clocks gated off |
| int_clk_on | output | 1 | Internal clocks kept running for debug |
| vreg_active | output | 1 | Regulator held in full-power mode |
| pdown | output | 1 | Power-down control for the deep state |
| illegal_rst | output | 1 | Illegal-opcode reset request pulse |
| wake | output | 1 | Wake event pulse |
| wake_cause | output | 1 | With `wake`: 1 = reset pin, 0 = interrupt |
| done | output | 1 | Resume pulse to the CPU |
| mode_o | output | 2 | Held stop state code |

## Verification
Every result comes from a register, so each one appears exactly one clock edge after the stimulus that causes it. The only exception is `done`, which comes one edge after `wake`, two edges after the wake source. The bench drives inputs on the falling edge. Its reference model advances on the same rising edge as the design, and every output is compared with that model on the next falling edge, so each expected value is sampled in the cycle it is due. The directed checks (mode held against input changes, cause after a combined wake, abort) also sample on a falling edge, counted from the edge that launched the stimulus.

// File: rtl/stopctl_pkg.sv
package stopctl_pkg;

    typedef enum logic [1:0] {
        MODE_RUN     = 2'b00,
        MODE_SHALLOW = 2'b01,
        MODE_SHL_REG = 2'b10,
        MODE_DEEP    = 2'b11
    } stop_mode_e;

    typedef enum logic [1:0] {
        PH_RUN  = 2'b00,
        PH_STOP = 2'b01,
        PH_WAKE = 2'b10
    } stop_phase_e;

    typedef struct packed {
        logic stop_en;
        logic dbg_en;
        logic lvd_en;
        logic lvd_stop_en;
        logic pdown_sel;
    } stop_cfg_t;

    typedef struct packed {
        logic hit;
        logic by_pin;
    } wake_info_t;

    // Priority: debug first, then low-voltage hold, then power-down select.
    function automatic stop_mode_e pick_mode(input stop_cfg_t c);
        if (c.dbg_en)
            return MODE_SHALLOW;
        else if (c.lvd_en && c.lvd_stop_en)
            return MODE_SHL_REG;
        else if (c.pdown_sel)
            return MODE_DEEP;
        else
            return MODE_SHALLOW;
    endfunction

endpackage

// File: rtl/stop_mode_sel.sv
module stop_mode_sel
    import stopctl_pkg::*;
(
    input  stop_cfg_t  cfg,
    output stop_mode_e mode,
    output logic       keep_clk,
    output logic       allowed
);
    always_comb begin
        mode     = pick_mode(cfg);
        keep_clk = cfg.dbg_en;
        allowed  = cfg.stop_en;
    end
endmodule

// File: rtl/stop_wake_detect.sv
module stop_wake_detect
    import stopctl_pkg::*;
#(
    parameter int NSRC = 6
) (
    input  logic [NSRC-1:0] req,
    input  logic [NSRC-1:0] en,
    input  logic            pin,
    output logic            irq_hit,
    output wake_info_t      info
);
    logic [NSRC-1:0] masked;

    for (genvar i = 0; i < NSRC; i++) begin : g_mask
        assign masked[i] = req[i] & en[i];
    end

    always_comb begin
        irq_hit     = |masked;
        info.by_pin = pin;
        info.hit    = pin | irq_hit;
    end
endmodule

// File: rtl/stop_seq.sv
module stop_seq
    import stopctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       stop_req,
    input  logic       allowed,
    input  stop_mode_e sel_mode,
    input  logic       sel_keep_clk,
    input  logic       abort_hit,
    input  wake_info_t wk,
    output stop_phase_e phase,
    output stop_mode_e mode,
    output logic       keep_clk,
    output logic       ill_p,
    output logic       wake_p,
    output logic       cause_p,
    output logic       done_p
);
    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_RUN;
            mode     <= MODE_RUN;
            keep_clk <= 1'b0;
            ill_p    <= 1'b0;
            wake_p   <= 1'b0;
            cause_p  <= 1'b0;
            done_p   <= 1'b0;
        end else begin
            ill_p   <= 1'b0;
            wake_p  <= 1'b0;
            cause_p <= 1'b0;
            done_p  <= 1'b0;
            unique case (phase)
                PH_RUN: begin
                    if (stop_req) begin
                        if (!allowed) begin
                            ill_p <= 1'b1;
                        end else if (abort_hit) begin
                            done_p <= 1'b1;
                        end else begin
                            phase    <= PH_STOP;
                            mode     <= sel_mode;
                            keep_clk <= sel_keep_clk;
                        end
                    end
                end
                PH_STOP: begin
                    if (wk.hit) begin
                        phase    <= PH_WAKE;
                        mode     <= MODE_RUN;
                        keep_clk <= 1'b0;
                        wake_p   <= 1'b1;
                        cause_p  <= wk.by_pin;
                    end
                end
                PH_WAKE: begin
                    phase  <= PH_RUN;
                    done_p <= 1'b1;
                end
                default: phase <= PH_RUN;
            endcase
        end
    end
endmodule

// File: rtl/stop_ctl.sv
module stop_ctl
    import stopctl_pkg::*;
#(
    parameter int NSRC = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            stop_req,
    input  logic            stop_en,
    input  logic            dbg_en,
    input  logic            lvd_en,
    input  logic            lvd_stop_en,
    input  logic            pdown_sel,
    input  logic            rst_pin,
    input  logic [NSRC-1:0] wake_req,
    input  logic [NSRC-1:0] wake_en,
    output logic            clk_gate,
    output logic            int_clk_on,
    output logic            vreg_active,
    output logic            pdown,
    output logic            illegal_rst,
    output logic            wake,
    output logic            wake_cause,
    output logic            done,
    output logic [1:0]      mode_o
);
    stop_cfg_t   cfg;
    stop_mode_e  sel_mode, cur_mode;
    stop_phase_e phase;
    wake_info_t  wk;
    logic        sel_keep, allowed, irq_hit, keep_q;

    assign cfg = '{stop_en: stop_en, dbg_en: dbg_en, lvd_en: lvd_en,
                   lvd_stop_en: lvd_stop_en, pdown_sel: pdown_sel};

    stop_mode_sel u_sel (
        .cfg      (cfg),
        .mode     (sel_mode),
        .keep_clk (sel_keep),
        .allowed  (allowed)
    );

    stop_wake_detect #(.NSRC(NSRC)) u_wake (
        .req     (wake_req),
        .en      (wake_en),
        .pin     (rst_pin),
        .irq_hit (irq_hit),
        .info    (wk)
    );

    stop_seq u_seq (
        .clk          (clk),
        .rst          (rst),
        .stop_req     (stop_req),
        .allowed      (allowed),
        .sel_mode     (sel_mode),
        .sel_keep_clk (sel_keep),
        .abort_hit    (irq_hit),
        .wk           (wk),
        .phase        (phase),
        .mode         (cur_mode),
        .keep_clk     (keep_q),
        .ill_p        (illegal_rst),
        .wake_p       (wake),
        .cause_p      (wake_cause),
        .done_p       (done)
    );

    always_comb begin
        clk_gate    = (phase == PH_STOP);
        int_clk_on  = keep_q;
        vreg_active = (cur_mode == MODE_SHL_REG);
        pdown       = (cur_mode == MODE_DEEP);
        mode_o      = cur_mode;
    end
endmodule

// File: rtl/stop_ctl_chk.sv
module stop_ctl_chk #(
    parameter int NSRC = 6
) (
    input logic            clk,
    input logic            rst,
    input logic            stop_req,
    input logic            stop_en,
    input logic            rst_pin,
    input logic [NSRC-1:0] wake_req,
    input logic [NSRC-1:0] wake_en,
    input logic            clk_gate,
    input logic            pdown,
    input logic            illegal_rst,
    input logic            wake,
    input logic            wake_cause,
    input logic            done,
    input logic [1:0]      mode_o
);
    logic in_run;
    assign in_run = !clk_gate && !wake;

    a_r1_illegal_pulse: assert property (@(posedge clk) disable iff (rst)
        (in_run && stop_req && !stop_en) |=> (illegal_rst && !clk_gate && mode_o == 2'b00));

    a_r5_gate_in_stop: assert property (@(posedge clk) disable iff (rst)
        (mode_o != 2'b00) |-> clk_gate);

    a_r4_pdown_only_stopped: assert property (@(posedge clk) disable iff (rst)
        pdown |-> clk_gate);

    a_r6_mode_held: assert property (@(posedge clk) disable iff (rst)
        (clk_gate && !rst_pin && ((wake_req & wake_en) == '0)) |=> (clk_gate && $stable(mode_o)));

    a_r8_pin_cause: assert property (@(posedge clk) disable iff (rst)
        (clk_gate && rst_pin) |=> (wake && wake_cause));

    a_r9_irq_cause: assert property (@(posedge clk) disable iff (rst)
        (clk_gate && !rst_pin && ((wake_req & wake_en) != '0)) |=> (wake && !wake_cause));

    a_r10_done_after_wake: assert property (@(posedge clk) disable iff (rst)
        wake |=> (done && !clk_gate));

    a_r10_gate_release: assert property (@(posedge clk) disable iff (rst)
        wake |-> (!clk_gate && mode_o == 2'b00));

    a_r11_abort: assert property (@(posedge clk) disable iff (rst)
        (in_run && stop_req && stop_en && ((wake_req & wake_en) != '0)) |=> (done && !clk_gate && !wake));
endmodule

bind stop_ctl stop_ctl_chk #(.NSRC(NSRC)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .stop_req    (stop_req),
    .stop_en     (stop_en),
    .rst_pin     (rst_pin),
    .wake_req    (wake_req),
    .wake_en     (wake_en),
    .clk_gate    (clk_gate),
    .pdown       (pdown),
    .illegal_rst (illegal_rst),
    .wake        (wake),
    .wake_cause  (wake_cause),
    .done        (done),
    .mode_o      (mode_o)
);

// File: tb/stop_ctl_tb_top.sv
module stop_ctl_tb_top;
    localparam int NSRC = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic stop_req = 0, stop_en = 0, dbg_en = 0, lvd_en = 0, lvd_stop_en = 0, pdown_sel = 0, rst_pin = 0;
    logic [NSRC-1:0] wake_req = '0, wake_en = '0;
    logic clk_gate, int_clk_on, vreg_active, pdown, illegal_rst, wake, wake_cause, done;
    logic [1:0] mode_o;

    always #4 clk = ~clk;

    stop_ctl #(.NSRC(NSRC)) dut_i (
        .clk(clk), .rst(rst), .stop_req(stop_req), .stop_en(stop_en), .dbg_en(dbg_en),
        .lvd_en(lvd_en), .lvd_stop_en(lvd_stop_en), .pdown_sel(pdown_sel), .rst_pin(rst_pin),
        .wake_req(wake_req), .wake_en(wake_en), .clk_gate(clk_gate), .int_clk_on(int_clk_on),
        .vreg_active(vreg_active), .pdown(pdown), .illegal_rst(illegal_rst), .wake(wake),
        .wake_cause(wake_cause), .done(done), .mode_o(mode_o)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // Behavioural reference: 0 run, 1 stopped, 2 waking
    int m_phase = 0;
    int m_mode = 0;
    int m_keep = 0, m_ill = 0, m_wake = 0, m_cause = 0, m_done = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_phase = 0; m_mode = 0; m_keep = 0;
            m_ill = 0; m_wake = 0; m_cause = 0; m_done = 0;
        end else begin
            m_ill = 0; m_wake = 0; m_cause = 0; m_done = 0;
            if (m_phase == 0) begin
                if (stop_req) begin
                    if (!stop_en) m_ill = 1;
                    else if ((wake_req & wake_en) != 0) m_done = 1;
                    else begin
                        m_phase = 1;
                        m_keep = dbg_en ? 1 : 0;
                        if (dbg_en) m_mode = 1;
                        else if (lvd_en && lvd_stop_en) m_mode = 2;
                        else m_mode = pdown_sel ? 3 : 1;
                    end
                end
            end else if (m_phase == 1) begin
                if (rst_pin || ((wake_req & wake_en) != 0)) begin
                    m_phase = 2; m_mode = 0; m_keep = 0;
                    m_wake = 1; m_cause = rst_pin ? 1 : 0;
                end
            end else begin
                m_phase = 0; m_done = 1;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && !finished) begin
            check(int'(mode_o) == m_mode, "R4 mode_o", int'(mode_o), m_mode);
            check(int'(clk_gate) == (m_phase == 1 ? 1 : 0), "R5 clk_gate", int'(clk_gate), m_phase == 1 ? 1 : 0);
            check(int'(int_clk_on) == m_keep, "R2 int_clk_on", int'(int_clk_on), m_keep);
            check(int'(vreg_active) == (m_mode == 2 ? 1 : 0), "R3 vreg_active", int'(vreg_active), m_mode == 2 ? 1 : 0);
            check(int'(pdown) == (m_mode == 3 ? 1 : 0), "R4 pdown", int'(pdown), m_mode == 3 ? 1 : 0);
            check(int'(illegal_rst) == m_ill, "R1 illegal_rst", int'(illegal_rst), m_ill);
            check(int'(wake) == m_wake, "R7 wake", int'(wake), m_wake);
            check(int'(wake_cause) == m_cause, "R8 wake_cause", int'(wake_cause), m_cause);
            check(int'(done) == m_done, "R10 done", int'(done), m_done);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_cfg(input bit se, input bit de, input bit le, input bit ls, input bit ps);
        stop_en = se; dbg_en = de; lvd_en = le; lvd_stop_en = ls; pdown_sel = ps;
    endtask

    task automatic pulse_stop();
        stop_req = 1; cyc(1); stop_req = 0;
    endtask

    initial begin
        cyc(2);
        rst = 0;
        // R12: reset state
        check(mode_o == 2'b00 && !clk_gate && !illegal_rst && !wake && !done && !pdown && !vreg_active,
              "R12 reset state", int'(mode_o), 0);

        // R1: stop disabled
        set_cfg(0, 1, 1, 1, 1);
        wake_en = '1; wake_req = 6'b000001;
        pulse_stop();
        check(illegal_rst == 1 && clk_gate == 0, "R1 illegal with stop off", int'(illegal_rst), 1);
        wake_req = '0; cyc(3);

        // R2: debug shallow, interrupt wake
        set_cfg(1, 1, 1, 1, 1);
        pulse_stop(); cyc(2);
        check(mode_o == 2'b01 && int_clk_on, "R2 debug shallow", int'(mode_o), 1);
        wake_req = 6'b000100; cyc(1); wake_req = '0;
        check(wake && !wake_cause, "R9 interrupt cause", int'(wake_cause), 0);
        cyc(3);

        // R3: demotion of deep request, R6 inputs ignored while stopped, R8 pin wake
        set_cfg(1, 0, 1, 1, 1);
        pulse_stop(); cyc(1);
        check(mode_o == 2'b10 && !pdown, "R3 demoted to regulator stop", int'(mode_o), 2);
        set_cfg(0, 1, 0, 0, 0);
        stop_req = 1; cyc(1); stop_req = 0; cyc(2);
        check(mode_o == 2'b10 && vreg_active && clk_gate, "R6 mode held", int'(mode_o), 2);
        rst_pin = 1; cyc(1); rst_pin = 0;
        check(wake && wake_cause && !clk_gate, "R8 pin wake", int'(wake_cause), 1);
        cyc(1);
        check(done == 1, "R10 done after wake", int'(done), 1);
        cyc(2);

        // R4 shallow, R7 masked source ignored
        set_cfg(1, 0, 1, 0, 0);
        wake_en = 6'b000011;
        pulse_stop(); cyc(1);
        check(mode_o == 2'b01 && !int_clk_on, "R4 shallow", int'(mode_o), 1);
        wake_req = 6'b110000; cyc(3); wake_req = '0;
        check(clk_gate && !wake, "R7 masked source ignored", int'(clk_gate), 1);
        wake_req = 6'b000010; cyc(1); wake_req = '0;
        check(wake && !wake_cause, "R9 enabled source wakes", int'(wake), 1);
        cyc(3);

        // R4 deep, R8 pin wins over interrupt
        set_cfg(1, 0, 0, 1, 1);
        pulse_stop(); cyc(1);
        check(mode_o == 2'b11 && pdown, "R4 deep", int'(mode_o), 3);
        rst_pin = 1; wake_req = 6'b000001; cyc(1); rst_pin = 0; wake_req = '0;
        check(wake && wake_cause, "R8 pin priority", int'(wake_cause), 1);
        cyc(3);

        // R11 abort
        set_cfg(1, 0, 0, 0, 1);
        wake_req = 6'b000001; pulse_stop(); wake_req = '0;
        check(done && !clk_gate && !wake && mode_o == 2'b00, "R11 abort", int'(done), 1);
        cyc(4);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule